// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This unit performs one-bit shifts and rotates for an 8-bit accumulator machine that can also pair its two accumulators into one 16-bit register. Each accepted operation names a shift kind, an operand width, the operand bytes and the current condition code byte. One clock later the unit presents the shifted bytes and a condition code byte with carry, zero, negative and overflow recomputed.

In 16-bit mode the high operand byte (accumulator A) is the upper half of the word and the low byte (accumulator B) is the lower half. In 8-bit mode only the low byte is shifted. For memory targets the caller places the fetched byte on the low operand input. Fetching, addressing and write-back belong to the caller.

Top module: `acc_shifter`

## Requirements
- R1: Kind 0 (arithmetic left) and kind 1 (logical left) give identical results: the operand moves up one place, bit 0 becomes 0, and the carry (condition bit 0) takes the old top bit (bit 7 in 8-bit mode, bit 15 in 16-bit mode).
- R2: Kind 2 (arithmetic right) moves the operand down one place, keeps the old top bit in the top position, and clears the carry.
- R3: Kind 3 (logical right) moves the operand down one place, clears the top bit, and loads the carry from the old bit 0.
- R4: Kind 4 (rotate left) moves the old carry into bit 0 and the old top bit into the carry.
- R5: Kind 5 (rotate right) moves the old carry into the top bit and the old bit 0 into the carry.
- R6: With `wide_i` high the operand is `{hi_i, lo_i}` with `hi_i` as the upper byte; with `wide_i` low only `lo_i` is shifted and `hi_q` returns `hi_i` unchanged.
- R7: Zero (condition bit 2) is set exactly when the whole result of the selected width is zero; negative (condition bit 3) equals the result's top bit.
- R8: Overflow (condition bit 1) equals negative XOR carry after the operation, for kinds 0 to 5.
- R9: Condition bits 7 to 4 are copied from `ccr_i` to `ccr_q` unchanged.
- R10: Kinds 6 and 7 are undefined: both result bytes and the whole condition byte return the inputs unchanged.
- R11: Results appear on the clock edge after `go_i` is sampled high, with `done_q` high for that cycle only; while `go_i` is low `done_q` is low and the result and condition outputs hold their values.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Operation request, sampled each clock |
| kind_i | input | 3 | Shift kind code (0 to 5 defined, 6 and 7 undefined) |
| wide_i | input | 1 | 1 selects the 16-bit paired operand |
| hi_i | input | 8 | Upper operand byte (accumulator A) |
| lo_i | input | 8 | Lower operand byte, or the 8-bit operand |
| ccr_i | input | 8 | Current condition code byte |
| done_q | output | 1 | Result valid for one cycle |
| hi_q | output | 8 | Upper result byte |
| lo_q | output | 8 | Lower result byte |
| ccr_q | output | 8 | Updated condition code byte |

## Verification
The hardest cases to reach are those where flags disagree with the bit pattern at a glance: a left shift of 0x80 or 0x8000 that gives a zero result with carry set and overflow set, an arithmetic right shift of an odd value whose carry must still read zero, and 8-bit mode where a set bit in the upper byte must neither leak into the result nor affect zero and negative. The stimulus drives these as directed patterns in both widths and with carry-in both set and clear, then runs a long stream of random kinds, widths, operands and condition bytes with idle gaps, compared cycle by cycle against an integer model in the bench.

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [2:0]        kind_i,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [7:0]        ccr_i,
  output logic              done_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic [7:0]        ccr_q
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int C_BIT = 0;
  localparam int V_BIT = 1;
  localparam int Z_BIT = 2;
  localparam int N_BIT = 3;

  logic [WORD_W-1:0] src, sh, res;
  logic              top_in, cin, cout, neg, zero, known;
  int unsigned       top_idx;

  assign top_idx = wide_i ? WORD_W - 1 : BYTE_W - 1;
  assign src     = wide_i ? {hi_i, lo_i} : {{BYTE_W{1'b0}}, lo_i};
  assign top_in  = src[top_idx];
  assign cin     = ccr_i[C_BIT];

  always_comb begin
    sh    = src;
    cout  = cin;
    known = 1'b1;
    case (kind_i)
      3'd0, 3'd1: begin
        sh   = src << 1;
        cout = top_in;
      end
      3'd2: begin
        sh          = src >> 1;
        sh[top_idx] = top_in;
        cout        = 1'b0;
      end
      3'd3: begin
        sh   = src >> 1;
        cout = src[0];
      end
      3'd4: begin
        sh    = src << 1;
        sh[0] = cin;
        cout  = top_in;
      end
      3'd5: begin
        sh          = src >> 1;
        sh[top_idx] = cin;
        cout        = src[0];
      end
      default: known = 1'b0;
    endcase
  end

  assign res  = !known ? {hi_i, lo_i} :
                wide_i ? sh : {hi_i, sh[BYTE_W-1:0]};
  assign neg  = wide_i ? res[WORD_W-1] : res[BYTE_W-1];
  assign zero = wide_i ? (res == '0) : (res[BYTE_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      ccr_q  <= '0;
    end else begin
      done_q <= go_i;
      if (go_i) begin
        hi_q <= res[WORD_W-1:BYTE_W];
        lo_q <= res[BYTE_W-1:0];
        if (known) begin
          ccr_q[7:4]   <= ccr_i[7:4];
          ccr_q[N_BIT] <= neg;
          ccr_q[Z_BIT] <= zero;
          ccr_q[V_BIT] <= neg ^ cout;
          ccr_q[C_BIT] <= cout;
        end else begin
          ccr_q <= ccr_i;
        end
      end
    end
  end
endmodule

// File: rtl/acc_shifter_chk.sv
module acc_shifter_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_i,
  input logic [2:0]        kind_i,
  input logic              wide_i,
  input logic [BYTE_W-1:0] hi_i,
  input logic [BYTE_W-1:0] lo_i,
  input logic [7:0]        ccr_i,
  input logic              done_q,
  input logic [BYTE_W-1:0] hi_q,
  input logic [BYTE_W-1:0] lo_q,
  input logic [7:0]        ccr_q
);
  logic in_top, in_lsb, out_top;
  assign in_top  = wide_i ? hi_i[BYTE_W-1] : lo_i[BYTE_W-1];
  assign in_lsb  = lo_i[0];
  assign out_top = ccr_q[3];

  p_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && (kind_i == 3'd0 || kind_i == 3'd1) |=> !lo_q[0] && ccr_q[0] == $past(in_top));

  p_asr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i == 3'd2 |=> !ccr_q[0] && out_top == $past(in_top));

  p_lsr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i == 3'd3 |=> !out_top && ccr_q[0] == $past(in_lsb));

  p_rol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i == 3'd4 |=> lo_q[0] == $past(ccr_i[0]) && ccr_q[0] == $past(in_top));

  p_ror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i == 3'd5 |=> out_top == $past(ccr_i[0]) && ccr_q[0] == $past(in_lsb));

  p_narrow_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && !wide_i |=> hi_q == $past(hi_i));

  p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i < 3'd6 |=> ccr_q[1] == (ccr_q[3] ^ ccr_q[0]));

  p_upper_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> ccr_q[7:4] == $past(ccr_i[7:4]));

  p_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i && kind_i >= 3'd6 |=> hi_q == $past(hi_i) && lo_q == $past(lo_i) && ccr_q == $past(ccr_i));

  p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> done_q);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> !done_q && $stable(hi_q) && $stable(lo_q) && $stable(ccr_q));
endmodule

bind acc_shifter acc_shifter_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/acc_shifter_test.sv
module acc_shifter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_i = 1'b0;
  logic [2:0] kind_i = '0;
  logic       wide_i = 1'b0;
  logic [7:0] hi_i = '0, lo_i = '0, ccr_i = '0;
  logic       done_q;
  logic [7:0] hi_q, lo_q, ccr_q;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] e_hi = '0, e_lo = '0, e_ccr = '0;
  logic       e_done = 1'b0;

  always #5 clk = ~clk;

  acc_shifter uut (.*);

  function automatic string tag_of(int k, bit w);
    string t;
    case (k)
      0, 1: t = "R1";
      2: t = "R2";
      3: t = "R3";
      4: t = "R4";
      5: t = "R5";
      default: t = "R10";
    endcase
    return w ? {t, "/R6"} : t;
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if ({done_q, hi_q, lo_q, ccr_q} !== {e_done, e_hi, e_lo, e_ccr}) begin
      n_bad++;
      $display("FAIL %s: got done=%0d hi=%02h lo=%02h ccr=%02h, want done=%0d hi=%02h lo=%02h ccr=%02h",
               tag, done_q, hi_q, lo_q, ccr_q, e_done, e_hi, e_lo, e_ccr);
    end
  endtask

  task automatic model(int k, bit w, int a, int b, int f);
    int width = w ? 16 : 8;
    int v = w ? a * 256 + b : b;
    int top = 1 << (width - 1);
    int full = (1 << width) - 1;
    int cin = f % 2;
    int r, c, n, z;
    case (k)
      0, 1: begin c = (v & top) != 0; r = (v * 2) & full; end
      2: begin c = 0; r = (v / 2) | (v & top); end
      3: begin c = v % 2; r = v / 2; end
      4: begin c = (v & top) != 0; r = ((v * 2) & full) + cin; end
      5: begin c = v % 2; r = v / 2 + (cin ? top : 0); end
      default: begin
        e_hi = a[7:0]; e_lo = b[7:0]; e_ccr = f[7:0]; e_done = 1'b1;
        return;
      end
    endcase
    n = (r & top) != 0;
    z = (r == 0);
    e_hi  = w ? r[15:8] : a[7:0];
    e_lo  = r[7:0];
    e_ccr = {f[7:4], n[0], z[0], n[0] ^ c[0], c[0]};
    e_done = 1'b1;
  endtask

  task automatic step(int k, bit w, int a, int b, int f, string extra = "");
    go_i = 1'b1; kind_i = k[2:0]; wide_i = w;
    hi_i = a[7:0]; lo_i = b[7:0]; ccr_i = f[7:0];
    model(k, w, a, b, f);
    @(negedge clk);
    compare({tag_of(k, w), " R7 R8 R9 R11", extra});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      go_i = 1'b0;
      hi_i = 8'h5A; lo_i = 8'hA5; ccr_i = 8'hFF; kind_i = 3'd3;
      e_done = 1'b0;
      @(negedge clk);
      compare("R11 hold");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, want under 50000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12 after release");

    // R1 alias equality and zero-with-carry corner
    step(0, 0, 8'h33, 8'h80, 8'h00, " R1 zero+carry");
    step(1, 0, 8'h33, 8'h80, 8'h00, " R1 alias");
    step(0, 1, 8'h80, 8'h00, 8'hF0, " R1 wide zero+carry");
    step(1, 1, 8'h41, 8'h81, 8'h01, " R1 wide alias");
    // R2 odd operand must still clear carry
    step(2, 0, 8'hFF, 8'h81, 8'h01, " R2 odd");
    step(2, 1, 8'h80, 8'h01, 8'h01, " R2 wide");
    // R3
    step(3, 0, 8'hFF, 8'h01, 8'h00, " R3 to zero");
    step(3, 1, 8'hFF, 8'hFF, 8'h00, " R3 wide");
    // R4 / R5 with carry in set and clear
    step(4, 0, 8'h00, 8'h80, 8'h01, " R4 cin1");
    step(4, 1, 8'h7F, 8'hFF, 8'h00, " R4 wide cin0");
    step(5, 0, 8'h00, 8'h01, 8'h00, " R5 cin0");
    step(5, 1, 8'h00, 8'h00, 8'h01, " R5 wide cin1");
    // R6 upper byte must not leak in 8-bit mode
    step(3, 0, 8'h80, 8'h00, 8'h00, " R6 narrow");
    // R10 undefined kinds
    step(6, 1, 8'h12, 8'h34, 8'hA5, " R10");
    step(7, 0, 8'hFE, 8'hDC, 8'h5A, " R10");
    idle(3);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) idle(1);
      step($urandom_range(0, 7), 1'($urandom_range(0, 1)),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
    end
    idle(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule